// File: doc/BRIEF.md
# GPIO Controller with Pin Interrupts

This block is a memory-mapped general-purpose I/O controller for a configurable number of pins (fewer than 32) behind a 32-bit word-addressed register interface. Software reads the synchronized pin levels. It drives outputs through two write-only strobe words, one that raises bits and one that lowers them, and chooses each pin's direction through a direction register. A build parameter picks whether a 1 in that register means "drive" or "float".

Each pin also feeds an event detector. A type bit selects level or edge sensing, and a polarity bit selects high/rising or low/falling. Detected events land in a pending register that software can read at any time. A pin contributes to the single registered, active-high interrupt line only when both its enable bit and its mask bit are set.

There is no automatic both-edge mode. Software emulates one by flipping the polarity bit after each event, and the hardware honours a polarity write from the very next clock.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After synchronous reset every register reads 0, `pin_out` is 0, `irq_out` is 0 and `bus_rdata` is 0.
- R2: Byte addresses 0x00 (direction), 0x14 (enable), 0x18 (type), 0x1C (polarity) and 0x24 (mask) read back the last value written, limited to the low NUM_PINS bits. Bits NUM_PINS..31 of every read are 0, and the unmapped word 0x08 reads 0. Read data appears on `bus_rdata` the cycle after `bus_rd` and is 0 otherwise.
- R3: A write to 0x0C sets `pin_out` bits where the data bit is 1, and a write to 0x10 clears them. Zero data bits leave outputs unchanged. Reading either address returns the output latch. `pin_out` changes on the edge that takes the write.
- R4: With OE_IS_INPUT=0, `pin_oe` equals the direction register. With OE_IS_INPUT=1, `pin_oe` is its bitwise inverse (1 = pin driven).
- R5: Address 0x04 reads the pin levels after a two-flop synchronizer, so a level held for three clocks is visible. Writes to 0x04 have no effect.
- R6: With type bit 0 (edge), polarity 1 latches a pending bit on a rising edge and polarity 0 on a falling edge. The bit stays set after the pin returns.
- R7: With type bit 1 (level), the pending bit is 1 exactly while the synchronized pin equals the polarity bit and the pin is enabled.
- R8: Writing 1 to a bit of 0x20 clears an edge pending bit. A pin whose enable bit is 0 never holds a pending bit, and clearing enable clears it on the next clock.
- R9: `irq_out` is the registered OR of pending AND enable AND mask. A pending bit with mask 0 stays readable but does not raise `irq_out`.
- R10: A polarity write is used for detection from the next clock, so software can rearm a pin for the opposite edge after an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | NUM_PINS | Asynchronous pin levels |
| pin_out | output | NUM_PINS | Output data latch |
| pin_oe | output | NUM_PINS | Per-pin drive enable, 1 = drive |
| irq_out | output | 1 | Registered interrupt request |

## Verification
The bench builds two copies with NUM_PINS=24 that share one bus: one with OE_IS_INPUT=0 and one with OE_IS_INPUT=1. Comparing their `pin_oe` after the same direction write covers both senses of the direction register. The 24-pin width leaves eight upper data bits unused, so writes of all ones show that the unused upper read bits stay zero.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int BUS_W = 32;
  // Word indices (byte address / 4)
  localparam int IDX_DIR  = 0;
  localparam int IDX_LVL  = 1;
  localparam int IDX_SET  = 3;
  localparam int IDX_CLR  = 4;
  localparam int IDX_EN   = 5;
  localparam int IDX_TYP  = 6;
  localparam int IDX_POL  = 7;
  localparam int IDX_PND  = 8;
  localparam int IDX_MSK  = 9;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 24,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d_async;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_sync = stg[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int ADDR_W   = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wr,
  input  logic                rd,
  input  logic [BUS_W-1:0]    wdata,
  output logic [BUS_W-1:0]    rdata,
  input  logic [NUM_PINS-1:0] lvl_sync,
  input  logic [NUM_PINS-1:0] pend,
  output logic [NUM_PINS-1:0] dir_q,
  output logic [NUM_PINS-1:0] out_q,
  output logic [NUM_PINS-1:0] en_q,
  output logic [NUM_PINS-1:0] typ_q,
  output logic [NUM_PINS-1:0] pol_q,
  output logic [NUM_PINS-1:0] msk_q,
  output logic [NUM_PINS-1:0] pend_clr
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0]   word;
  logic                aligned;
  logic [NUM_PINS-1:0] wd;
  logic                unused_wdata_hi;
  logic [NUM_PINS-1:0] rmux;

  assign word    = addr[ADDR_W-1:2];
  assign aligned = (addr[1:0] == 2'b00);
  assign wd      = wdata[NUM_PINS-1:0];
  assign unused_wdata_hi = ^wdata[BUS_W-1:NUM_PINS];

  function automatic logic hit(input logic [WORD_W-1:0] w, input int idx);
    return w == WORD_W'(idx);
  endfunction

  logic wr_ok;
  assign wr_ok = wr && aligned;

  assign pend_clr = (wr_ok && hit(word, IDX_PND)) ? wd : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '0;
      out_q <= '0;
      en_q  <= '0;
      typ_q <= '0;
      pol_q <= '0;
      msk_q <= '0;
    end else if (wr_ok) begin
      if (hit(word, IDX_DIR)) dir_q <= wd;
      if (hit(word, IDX_SET)) out_q <= out_q | wd;
      if (hit(word, IDX_CLR)) out_q <= out_q & ~wd;
      if (hit(word, IDX_EN))  en_q  <= wd;
      if (hit(word, IDX_TYP)) typ_q <= wd;
      if (hit(word, IDX_POL)) pol_q <= wd;
      if (hit(word, IDX_MSK)) msk_q <= wd;
    end
  end

  always_comb begin
    rmux = '0;
    if (aligned) begin
      if (hit(word, IDX_DIR)) rmux = dir_q;
      if (hit(word, IDX_LVL)) rmux = lvl_sync;
      if (hit(word, IDX_SET)) rmux = out_q;
      if (hit(word, IDX_CLR)) rmux = out_q;
      if (hit(word, IDX_EN))  rmux = en_q;
      if (hit(word, IDX_TYP)) rmux = typ_q;
      if (hit(word, IDX_POL)) rmux = pol_q;
      if (hit(word, IDX_PND)) rmux = pend;
      if (hit(word, IDX_MSK)) rmux = msk_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= {{(BUS_W-NUM_PINS){1'b0}}, rmux};
    else         rdata <= '0;
  end
endmodule

// File: rtl/gpio_evt.sv
module gpio_evt #(
  parameter int NUM_PINS = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] lvl,
  input  logic [NUM_PINS-1:0] en,
  input  logic [NUM_PINS-1:0] typ,
  input  logic [NUM_PINS-1:0] pol,
  input  logic [NUM_PINS-1:0] clr,
  output logic [NUM_PINS-1:0] pend
);
  logic [NUM_PINS-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= lvl;
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic rise, fall, edge_hit, lvl_hit;
    assign rise     = lvl[i] & ~prev[i];
    assign fall     = ~lvl[i] & prev[i];
    assign edge_hit = pol[i] ? rise : fall;
    assign lvl_hit  = (lvl[i] == pol[i]);

    always_ff @(posedge clk) begin
      if (rst || !en[i])  pend[i] <= 1'b0;
      else if (typ[i])    pend[i] <= lvl_hit;
      else if (edge_hit)  pend[i] <= 1'b1;
      else if (clr[i])    pend[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS    = 24,
  parameter int ADDR_W      = 6,
  parameter bit OE_IS_INPUT = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic                irq_out
);
  logic [NUM_PINS-1:0] lvl_s, dir_q, out_q, en_q, typ_q, pol_q, mask_q;
  logic [NUM_PINS-1:0] pend_q, pend_clr;

  gpio_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_async(pin_in), .q_sync(lvl_s)
  );

  gpio_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .wdata(bus_wdata), .rdata(bus_rdata), .lvl_sync(lvl_s), .pend(pend_q),
    .dir_q(dir_q), .out_q(out_q), .en_q(en_q), .typ_q(typ_q),
    .pol_q(pol_q), .msk_q(mask_q), .pend_clr(pend_clr)
  );

  gpio_evt #(.NUM_PINS(NUM_PINS)) u_evt (
    .clk(clk), .rst(rst), .lvl(lvl_s), .en(en_q), .typ(typ_q),
    .pol(pol_q), .clr(pend_clr), .pend(pend_q)
  );

  if (OE_IS_INPUT) begin : g_oe_inv
    assign pin_oe = ~dir_q;
  end else begin : g_oe_dir
    assign pin_oe = dir_q;
  end

  assign pin_out = out_q;

  always_ff @(posedge clk) begin
    if (rst) irq_out <= 1'b0;
    else     irq_out <= |(pend_q & en_q & mask_q);
  end
endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int ADDR_W   = 6
) (
  input logic                clk,
  input logic                rst,
  input logic                bus_wr,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [NUM_PINS-1:0] wdata_lo,
  input logic [31:0]         bus_rdata,
  input logic [NUM_PINS-1:0] pin_out,
  input logic                irq_out,
  input logic [NUM_PINS-1:0] pend,
  input logic [NUM_PINS-1:0] en,
  input logic [NUM_PINS-1:0] mask
);
  localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(IDX_SET * 4);
  localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(IDX_CLR * 4);

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[31:NUM_PINS] == '0); // R2

  AST_SET_DRIVES: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_SET) |=> ((pin_out & $past(wdata_lo)) == $past(wdata_lo))); // R3

  AST_CLR_DRIVES: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_CLR) |=> ((pin_out & $past(wdata_lo)) == '0)); // R3

  AST_NO_PEND_DISABLED: assert property (@(posedge clk) disable iff (rst)
    (pend & ~$past(en)) == '0); // R8

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> $past(|(pend & en & mask))); // R9
endmodule

bind gpio_irq_ctrl gpio_irq_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .wdata_lo(bus_wdata[NUM_PINS-1:0]), .bus_rdata(bus_rdata),
  .pin_out(pin_out), .irq_out(irq_out), .pend(pend_q), .en(en_q), .mask(mask_q)
);

// File: tb/gpio_irq_ctrl_bench.sv
module gpio_irq_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 24;
  localparam int AW = 6;
  localparam logic [31:0] PM = 32'h00FF_FFFF;

  localparam logic [AW-1:0] A_DIR = 6'h00, A_LVL = 6'h04, A_GAP = 6'h08,
    A_SET = 6'h0C, A_CLR = 6'h10, A_EN = 6'h14, A_TYP = 6'h18,
    A_POL = 6'h1C, A_PND = 6'h20, A_MSK = 6'h24;

  // {addr(8), write data(32), expected read(32)}
  localparam int NV = 8;
  localparam logic [71:0] VEC [NV] = '{
    {8'h00, 32'hFFFF_FFFF, 32'h00FF_FFFF},
    {8'h14, 32'h1234_5678, 32'h0034_5678},
    {8'h18, 32'hA5A5_A5A5, 32'h00A5_A5A5},
    {8'h1C, 32'h5A5A_5A5A, 32'h005A_5A5A},
    {8'h24, 32'hFF00_00FF, 32'h0000_00FF},
    {8'h04, 32'hFFFF_FFFF, 32'h0000_0000},
    {8'h08, 32'hFFFF_FFFF, 32'h0000_0000},
    {8'h00, 32'h0000_0000, 32'h0000_0000}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0, bus_rdata, rdata_b;
  logic [NP-1:0] pin_in = '0, pin_out, pin_oe, pin_out_b, pin_oe_b;
  logic irq_out, irq_b;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_ctrl #(.NUM_PINS(NP), .ADDR_W(AW), .OE_IS_INPUT(1'b0)) u_gpio_irq_ctrl (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out));

  gpio_irq_ctrl #(.NUM_PINS(NP), .ADDR_W(AW), .OE_IS_INPUT(1'b1)) u_inv (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_b), .pin_in(pin_in),
    .pin_out(pin_out_b), .pin_oe(pin_oe_b), .irq_out(irq_b));

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic bw(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic br(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    settle(3);
    rst = 1'b0;
    // R1: reset state
    check("R1 rdata", bus_rdata, '0);
    check("R1 pin_out", {8'h0, pin_out}, '0);
    check("R1 irq", {31'h0, irq_out}, '0);
    br(A_PND, d); check("R1 pending", d, '0);
    br(A_EN, d);  check("R1 enable", d, '0);
    br(A_SET, d); check("R1 out latch", d, '0);

    // R2 / R5: table of write-then-readback vectors
    for (int i = 0; i < NV; i++) begin
      bw(VEC[i][AW-1+64:64], VEC[i][63:32]);
      br(VEC[i][AW-1+64:64], d);
      check("R2 table readback", d, VEC[i][31:0]);
    end
    bw(A_EN, '0); bw(A_TYP, '0); bw(A_POL, '0); bw(A_MSK, '0);

    // R4: direction sense in both builds
    bw(A_DIR, 32'h0000_F0F0);
    check("R4 oe normal", {8'h0, pin_oe}, 32'h0000_F0F0);
    check("R4 oe inverted", {8'h0, pin_oe_b}, 32'h00FF_0F0F);

    // R3: set/clear strobes
    bw(A_SET, 32'h0000_0081);
    check("R3 set", {8'h0, pin_out}, 32'h81);
    bw(A_SET, 32'h0000_0100);
    check("R3 set keeps", {8'h0, pin_out}, 32'h181);
    bw(A_CLR, 32'h0000_0001);
    check("R3 clear", {8'h0, pin_out}, 32'h180);
    br(A_SET, d); check("R3 read set addr", d, 32'h180);
    br(A_CLR, d); check("R3 read clr addr", d, 32'h180);

    // R5: synchronized input and ignored writes
    pin_in = 24'hAB_CDEF; settle(3);
    br(A_LVL, d); check("R5 input level", d, 32'h00AB_CDEF);
    bw(A_LVL, 32'h0000_0000);
    br(A_LVL, d); check("R5 write ignored", d, 32'h00AB_CDEF);
    pin_in = '0; settle(4);

    // Interrupt setup: pin0 edge rising, pin1 level high
    bw(A_TYP, 32'h2); bw(A_POL, 32'h3); bw(A_EN, 32'h3); bw(A_MSK, 32'h1);
    bw(A_PND, PM); settle(2);
    br(A_PND, d); check("R7 level idle", d, 32'h0);

    // R6 rising edge, sticky; R9 irq
    pin_in[0] = 1'b1; settle(5);
    br(A_PND, d); check("R6 rise pending", d, 32'h1);
    check("R9 irq raised", {31'h0, irq_out}, 32'h1);
    pin_in[0] = 1'b0; settle(5);
    br(A_PND, d); check("R6 sticky", d, 32'h1);
    bw(A_PND, 32'h1); settle(2);
    br(A_PND, d); check("R8 w1c", d, 32'h0);
    check("R9 irq dropped", {31'h0, irq_out}, 32'h0);

    // R10: rearm for falling edge
    pin_in[0] = 1'b1; settle(5);
    bw(A_POL, 32'h2); bw(A_PND, 32'h1);
    br(A_PND, d); check("R10 no event on pol flip", d, 32'h0);
    pin_in[0] = 1'b0; settle(5);
    br(A_PND, d); check("R10 falling after rearm", d, 32'h1);
    bw(A_PND, 32'h1); settle(2);

    // R7 level, R9 mask
    pin_in[1] = 1'b1; settle(5);
    br(A_PND, d); check("R7 level pending", d, 32'h2);
    check("R9 masked no irq", {31'h0, irq_out}, 32'h0);
    bw(A_MSK, 32'h3); settle(2);
    check("R9 unmasked irq", {31'h0, irq_out}, 32'h1);
    pin_in[1] = 1'b0; settle(5);
    br(A_PND, d); check("R7 level follows", d, 32'h0);
    check("R7 irq drops", {31'h0, irq_out}, 32'h0);

    // R8: disabled pin, and disable clears pending
    bw(A_POL, 32'h7);
    pin_in[2] = 1'b1; settle(5);
    br(A_PND, d); check("R8 disabled pin", d, 32'h0);
    pin_in[0] = 1'b1; settle(5);
    br(A_PND, d); check("R6 rise again", d, 32'h1);
    bw(A_EN, 32'h2); settle(2);
    br(A_PND, d); check("R8 disable clears", d, 32'h0);
    check("R8 irq off", {31'h0, irq_out}, 32'h0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule